// File: doc/BRIEF.md
# Shared Command-Gated Byte FIFO

This block is one 64-entry, 8-bit FIFO that carries bytes in both directions between a host processor and an internal command engine. The host reaches it through a single data port. A write pushes a byte and a read pops the byte at the head. The host can also read the current fill level and the overflow flag, and can issue a flush. The engine has its own push and pop port onto the same storage. Both sides may use the buffer in the same cycle.

While a command is running (`cmd_active` high), a permission decode keyed on `cmd_code` decides whether host pushes and host pops are allowed. A host access that the command does not permit is dropped and raises a sticky violation flag, one flag for writes and one for reads. When no command is running, every host access is allowed. If both sides push in the same cycle, or both pop, the engine is served and the host sees `host_ready` low for that cycle.

Top module: `shared_byte_fifo`

## Requirements
- R1: A synchronous active-high reset leaves the level at 0, clears the overflow flag and both violation flags, and leaves `host_ready` high when there is no collision.
- R2: Bytes leave in the order they entered, whichever port pushed them. `host_rdata` and `eng_rdata` show the head byte during the same cycle as the pop strobe.
- R3: `level` is a 7-bit register equal to the number of stored bytes (0 to 64). It changes only on the clock edge after an accepted push or pop.
- R4: A push while the level is 64 and no pop is accepted in the same cycle is dropped. It sets `ovf_flag`, which stays set until a flush or reset.
- R5: A pop while the level is 0 changes nothing, and the read data outputs show 0x00 while the buffer is empty.
- R6: A cycle with `host_flush` high empties the buffer and clears `ovf_flag`, `wr_viol` and `rd_viol`. Every push and pop offered in that cycle is ignored.
- R7: With `cmd_active` low, host pushes and pops are always allowed.
- R8: With `cmd_active` high, host permission follows the 4-bit `cmd_code`:
  - Codes 1, 4, 6, 7, 8, 10 and 11 allow writes only.
  - Code 2 allows reads only.
  - Codes 0, 3 and 5 allow both.
  - Codes 9 and 12 to 15 allow neither.

  A forbidden host write or read leaves the buffer unchanged and sets the sticky `wr_viol` or `rd_viol` flag.
- R9: A push on one port and a pop on the other in the same cycle are both applied, so the level changes by their net effect.
- R10: When the host and the engine both push, or both pop, in the same cycle, only the engine operation takes effect. `host_ready` is low in that cycle, and the whole host access of that cycle is ignored.
- R11: Read and write positions wrap modulo 64, and order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_active | input | 1 | A command is running |
| cmd_code | input | 4 | Code of the running command |
| host_wr | input | 1 | Host push strobe |
| host_rd | input | 1 | Host pop strobe |
| host_wdata | input | 8 | Host push data |
| host_flush | input | 1 | Empty the buffer and clear the flags |
| host_rdata | output | 8 | Head byte (0x00 when empty) |
| host_ready | output | 1 | Low when the host access loses to the engine |
| level | output | 7 | Number of stored bytes |
| ovf_flag | output | 1 | Sticky overflow |
| wr_viol | output | 1 | Sticky forbidden-write flag |
| rd_viol | output | 1 | Sticky forbidden-read flag |
| eng_push | input | 1 | Engine push strobe |
| eng_pop | input | 1 | Engine pop strobe |
| eng_wdata | input | 8 | Engine push data |
| eng_rdata | output | 8 | Head byte for the engine |

## Verification
The buffer is exercised with the following patterns, each aimed at a different kind of fault:

- **Lone pushes and pops from each side.** These show whether data ordering and the level count are right.
- **Host push against engine pop, and same-direction collisions.** These separate net-effect accounting from the engine-wins arbitration and its `host_ready` stall.
- **The same host access under several command codes.** This shows whether the permission decode, and the violation flag chosen, match each code group.
- **A full fill, an overflow attempt, a partial drain, a refill across the wrap point, an empty pop, and a flush.** These separate pointer wrap faults from level saturation faults and from flag clearing faults.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [3:0] {
    CMD_IDLE    = 4'd0,
    CMD_TX      = 4'd1,
    CMD_RX      = 4'd2,
    CMD_TRX     = 4'd3,
    CMD_MEM_WR  = 4'd4,
    CMD_MEM_RD  = 4'd5,
    CMD_KEY_MEM = 4'd6,
    CMD_KEY_LD  = 4'd7,
    CMD_AUTH_A  = 4'd8,
    CMD_AUTH_B  = 4'd9,
    CMD_CFG_LD  = 4'd10,
    CMD_CRC     = 4'd11,
    CMD_BOOT    = 4'd12
  } cmd_e;

  typedef struct packed {
    logic wr;
    logic rd;
  } perm_t;

  // Host permission for a running command
  function automatic perm_t cmd_perm(input logic [3:0] code);
    perm_t p;
    case (code)
      CMD_IDLE, CMD_TRX, CMD_MEM_RD:              p = '{wr: 1'b1, rd: 1'b1};
      CMD_RX:                                      p = '{wr: 1'b0, rd: 1'b1};
      CMD_TX, CMD_MEM_WR, CMD_KEY_MEM, CMD_KEY_LD,
      CMD_AUTH_A, CMD_CFG_LD, CMD_CRC:             p = '{wr: 1'b1, rd: 1'b0};
      default:                                     p = '{wr: 1'b0, rd: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sbf_perm.sv
module sbf_perm (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       cmd_active,
  input  logic [3:0] cmd_code,
  input  logic       host_wr,
  input  logic       host_rd,
  output logic       wr_ok,
  output logic       rd_ok,
  output logic       wr_viol,
  output logic       rd_viol
);
  import sbf_pkg::*;

  perm_t perm;

  always_comb begin
    perm  = cmd_active ? cmd_perm(cmd_code) : '{wr: 1'b1, rd: 1'b1};
    wr_ok = host_wr & perm.wr;
    rd_ok = host_rd & perm.rd;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_viol <= 1'b0;
      rd_viol <= 1'b0;
    end else begin
      if (host_wr && !perm.wr) wr_viol <= 1'b1;
      if (host_rd && !perm.rd) rd_viol <= 1'b1;
    end
  end
endmodule

// File: rtl/sbf_arb.sv
module sbf_arb #(
  parameter int WIDTH = 8
) (
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_wr_ok,
  input  logic             host_rd_ok,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             eng_push,
  input  logic             eng_pop,
  input  logic [WIDTH-1:0] eng_wdata,
  output logic             host_ready,
  output logic             push,
  output logic             pop,
  output logic [WIDTH-1:0] push_data
);
  always_comb begin
    host_ready = !((host_wr && eng_push) || (host_rd && eng_pop));
    push       = eng_push || (host_wr_ok && host_ready);
    pop        = eng_pop  || (host_rd_ok && host_ready);
    push_data  = eng_push ? eng_wdata : host_wdata;
  end
endmodule

// File: rtl/sbf_core.sv
module sbf_core #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             ovf
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             empty, full, pop_do, push_do, push_drop;

  always_comb begin
    empty     = (level == '0);
    full      = (level == FULL_LVL);
    pop_do    = pop && !empty;
    push_do   = push && (!full || pop_do);
    push_drop = push && full && !pop_do;
    head      = empty ? '0 : mem[rd_ptr];
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_do && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_do) wr_ptr <= wr_ptr + 1'b1;
      if (pop_do)  rd_ptr <= rd_ptr + 1'b1;
      if (push_do && !pop_do)      level <= level + 1'b1;
      else if (pop_do && !push_do) level <= level - 1'b1;
      if (push_drop) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/shared_byte_fifo.sv
module shared_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_active,
  input  logic [3:0]       cmd_code,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_flush,
  output logic [WIDTH-1:0] host_rdata,
  output logic             host_ready,
  output logic [LVL_W-1:0] level,
  output logic             ovf_flag,
  output logic             wr_viol,
  output logic             rd_viol,
  input  logic             eng_push,
  input  logic             eng_pop,
  input  logic [WIDTH-1:0] eng_wdata,
  output logic [WIDTH-1:0] eng_rdata
);
  logic             wr_ok, rd_ok, push, pop;
  logic [WIDTH-1:0] push_data, head;

  sbf_perm u_perm (
    .clk(clk), .rst(rst), .flush(host_flush),
    .cmd_active(cmd_active), .cmd_code(cmd_code),
    .host_wr(host_wr), .host_rd(host_rd),
    .wr_ok(wr_ok), .rd_ok(rd_ok),
    .wr_viol(wr_viol), .rd_viol(rd_viol)
  );

  sbf_arb #(.WIDTH(WIDTH)) u_arb (
    .host_wr(host_wr), .host_rd(host_rd),
    .host_wr_ok(wr_ok), .host_rd_ok(rd_ok),
    .host_wdata(host_wdata),
    .eng_push(eng_push), .eng_pop(eng_pop), .eng_wdata(eng_wdata),
    .host_ready(host_ready), .push(push), .pop(pop), .push_data(push_data)
  );

  sbf_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .flush(host_flush),
    .push(push), .push_data(push_data), .pop(pop),
    .head(head), .level(level), .ovf(ovf_flag)
  );

  assign host_rdata = head;
  assign eng_rdata  = head;
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             host_rd,
  input logic             host_flush,
  input logic             host_ready,
  input logic [WIDTH-1:0] host_rdata,
  input logic [LVL_W-1:0] level,
  input logic             ovf_flag,
  input logic             wr_viol,
  input logic             rd_viol,
  input logic             eng_push,
  input logic             eng_pop
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (level == '0 && !ovf_flag && !wr_viol && !rd_viol));

  a_r3_level_step: assert property (@(posedge clk) disable iff (rst)
    !host_flush |=> (level == $past(level) || level == $past(level) + 1'b1
                     || level + 1'b1 == $past(level)));

  always_ff @(posedge clk) begin
    if (!rst) a_r3_level_max: assert (level <= FULL_LVL);
  end

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !host_flush) |=> ovf_flag);

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> (host_rdata == '0));

  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    host_flush |=> (level == '0 && !ovf_flag && !wr_viol && !rd_viol));

  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    ((host_wr && eng_push) || (host_rd && eng_pop)) |-> !host_ready);
endmodule

bind shared_byte_fifo sbf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_flush(host_flush), .host_ready(host_ready), .host_rdata(host_rdata),
  .level(level), .ovf_flag(ovf_flag), .wr_viol(wr_viol), .rd_viol(rd_viol),
  .eng_push(eng_push), .eng_pop(eng_pop)
);

// File: tb/shared_byte_fifo_tb.sv
module shared_byte_fifo_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_active = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_flush = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic       eng_push = 1'b0, eng_pop = 1'b0;
  logic [7:0] eng_wdata = 8'd0;
  logic [7:0] host_rdata, eng_rdata;
  logic       host_ready, ovf_flag, wr_viol, rd_viol;
  logic [6:0] level;

  int checks = 0;
  int errors = 0;
  logic [7:0] s_head, s_ehead;
  logic       s_ready;

  always #4 clk = ~clk;

  shared_byte_fifo u_dut (
    .clk(clk), .rst(rst), .cmd_active(cmd_active), .cmd_code(cmd_code),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_flush(host_flush), .host_rdata(host_rdata), .host_ready(host_ready),
    .level(level), .ovf_flag(ovf_flag), .wr_viol(wr_viol), .rd_viol(rd_viol),
    .eng_push(eng_push), .eng_pop(eng_pop), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata)
  );

  typedef struct packed {
    logic       act;
    logic [3:0] code;
    logic       hwr;
    logic       hrd;
    logic [7:0] hd;
    logic       ew;
    logic       er;
    logic [7:0] ed;
    logic       rdy;
    logic [7:0] head;
    logic [6:0] lvl;
    logic       wv;
    logic       rv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 7'd1, 1'b0, 1'b0},
    '{1'b0, 4'd0, 1'b1, 1'b0, 8'h22, 1'b0, 1'b0, 8'h00, 1'b1, 8'h11, 7'd2, 1'b0, 1'b0},
    '{1'b0, 4'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h33, 1'b1, 8'h11, 7'd3, 1'b0, 1'b0},
    '{1'b0, 4'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h11, 7'd2, 1'b0, 1'b0},
    '{1'b0, 4'd0, 1'b1, 1'b0, 8'h44, 1'b0, 1'b1, 8'h00, 1'b1, 8'h22, 7'd2, 1'b0, 1'b0},
    '{1'b0, 4'd0, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0, 8'h66, 1'b0, 8'h33, 7'd3, 1'b0, 1'b0},
    '{1'b1, 4'd2, 1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 8'h00, 1'b1, 8'h33, 7'd3, 1'b1, 1'b0},
    '{1'b1, 4'd2, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h33, 7'd2, 1'b1, 1'b0},
    '{1'b1, 4'd1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h44, 7'd2, 1'b1, 1'b1},
    '{1'b1, 4'd3, 1'b1, 1'b1, 8'h88, 1'b0, 1'b0, 8'h00, 1'b1, 8'h44, 7'd2, 1'b1, 1'b1},
    '{1'b1, 4'd9, 1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 8'h00, 1'b1, 8'h66, 7'd2, 1'b1, 1'b1},
    '{1'b0, 4'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 8'h66, 7'd1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic act, input logic [3:0] code, input logic hwr,
                     input logic hrd, input logic [7:0] hd, input logic ew,
                     input logic er, input logic [7:0] ed, input logic fl);
    cmd_active = act; cmd_code = code; host_wr = hwr; host_rd = hrd;
    host_wdata = hd; eng_push = ew; eng_pop = er; eng_wdata = ed;
    host_flush = fl;
    #1;
    s_head = host_rdata; s_ehead = eng_rdata; s_ready = host_ready;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; eng_push = 1'b0; eng_pop = 1'b0;
    host_flush = 1'b0; cmd_active = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 viol", {wr_viol, rd_viol}, 0);
    #1; chk("R1 ready", host_ready, 1);
    chk("R5 empty head", host_rdata, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      cyc(v.act, v.code, v.hwr, v.hrd, v.hd, v.ew, v.er, v.ed, 1'b0);
      chk("R2 host head", s_head, v.head);
      chk("R2 eng head", s_ehead, v.head);
      chk("R10 ready", s_ready, v.rdy);
      if (i == 4)
        chk("R9 net level", level, v.lvl);
      else if (v.act)
        chk("R8 level", level, v.lvl);
      else
        chk("R7 level", level, v.lvl);
      chk("R8 viol", {wr_viol, rd_viol}, {v.wv, v.rv});
    end

    // R6 flush with a concurrent push that must be ignored
    cyc(1'b0, 4'd0, 1'b1, 1'b0, 8'hAB, 1'b0, 1'b0, 8'h00, 1'b1);
    chk("R6 level", level, 0);
    chk("R6 flags", {ovf_flag, wr_viol, rd_viol}, 0);

    // R4 fill to 64 then overflow
    for (int k = 0; k < 64; k++)
      cyc(1'b0, 4'd0, 1'b1, 1'b0, 8'(k), 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R3 full level", level, 64);
    chk("R4 no ovf yet", ovf_flag, 0);
    cyc(1'b0, 4'd0, 1'b1, 1'b0, 8'hEE, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R4 level held", level, 64);
    chk("R4 ovf set", ovf_flag, 1);

    // R11 drain 10, refill 10 across the wrap point
    for (int k = 0; k < 10; k++) begin
      cyc(1'b0, 4'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R2 drain order", s_head, k);
    end
    for (int k = 64; k < 74; k++)
      cyc(1'b0, 4'd0, 1'b1, 1'b0, 8'(k), 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R11 refill level", level, 64);
    for (int k = 10; k < 74; k++) begin
      cyc(1'b0, 4'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R11 wrap order", s_head, k);
    end
    chk("R3 drained level", level, 0);

    // R5 empty pop
    cyc(1'b0, 4'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0);
    chk("R5 empty data", s_head, 0);
    chk("R5 level stays", level, 0);
    chk("R4 ovf sticky", ovf_flag, 1);
    cyc(1'b0, 4'd0, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0);
    #1; chk("R5 pointers kept", host_rdata, 8'h5A);
    @(negedge clk);

    cyc(1'b0, 4'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
    chk("R6 ovf cleared", ovf_flag, 0);
    chk("R6 level cleared", level, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule